// File: doc/BRIEF.md
# Multi-Port Pin Register Bank

This block is a general-purpose I/O register bank attached to an APB bus. It holds up to four independent pin ports. Each port is up to 32 bits wide and has three read/write registers: an output value, a direction (1 = drive the pin), and an ownership select. The ownership select decides, pin by pin, whether the driven level comes from the software output value or from a hardware source input supplied by another block on the chip.

Each port also has a read-only register that returns the levels on its external pins after a two-stage synchronizer. Two read-only configuration words describe the instance to software: one gives the number of ports, the other gives each port's width. Software can therefore find the layout without build-time knowledge. The port count and the four port widths are parameters. Each port occupies a fixed 32-bit slot on the pin vectors, and bits above a port's width are inert.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset, every output-value, direction and ownership register of every port reads 0, and `padOut` and `padOe` are all 0.
- R2: Port p (p = 0..NUM_PORTS-1) has its output-value register at byte offset 12*p, its direction register at 12*p+4 and its ownership register at 12*p+8. Each register reads back the last value written in an access phase.
- R3: Bit i of `padOe` slot p equals bit i of port p's direction register, with 1 meaning the pin is driven.
- R4: Bit i of `padOut` slot p equals the ownership-register bit selecting between two sources. When the ownership bit is 0 it takes the output-value register bit. When the ownership bit is 1 it takes `hwIn` bit i of slot p.
- R5: A read of byte offset 0x50+4*p returns port p's `pinIn` slot through a two-flop synchronizer. A pin level present at a rising edge k is returned by a read whose access phase follows edge k+1. A level that first appears after edge k-1 is not yet visible in an access phase that follows edge k.
- R6: Offset 0x70 reads, for each implemented port p, its width minus one in bits [5p+4:5p]. Fields of absent ports and bits [31:20] read 0.
- R7: Offset 0x74 reads NUM_PORTS-1 in bits [3:2], with all other bits 0.
- R8: `pready` is always 1 and `pslverr` is always 0, so every transfer completes with no wait state.
- R9: The following are ignored: writes to the pin-level, configuration or unmapped offsets, and writes to the register group of a port at or above NUM_PORTS. Reads of unmapped offsets, and of register groups of absent ports, return 0.
- R10: Register bits at or above a port's width read 0, and the `padOut` and `padOe` bits of those positions are 0.
- R11: A write takes effect only in the access phase (`psel`, `penable` and `pwrite` all high). A setup phase alone changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write (1) / read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access phase |
| pready | output | 1 | Transfer complete, tied high |
| pslverr | output | 1 | Transfer error, tied low |
| pinIn | input | 4*32 | External pin levels, 32-bit slot per port |
| hwIn | input | 4*32 | Hardware source levels for pins owned by hardware |
| padOut | output | 4*32 | Level driven to each pin |
| padOe | output | 4*32 | Drive enable for each pin |

## Verification
A register write commits on the rising edge that ends its access phase. `padOut` and `padOe` reflect it from that edge on. A change on `hwIn` reaches `padOut` in the same cycle, with no register in the path. Read data is combinational during the access phase. A pin-level read sees the value that was on the pins two rising edges before the edge that ends the access phase.

The bench drives every input just after a falling edge and samples one time unit later, still before the next rising edge. It places pin changes either in the same cycle as a read's setup phase, so the old level is expected, or one cycle earlier, so the new level is expected.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  localparam int MAX_PORTS = 4;
  localparam int SLOT_W    = 32;
  localparam int PIN_W     = MAX_PORTS * SLOT_W;

  localparam logic [1:0] REG_DATA = 2'd0;
  localparam logic [1:0] REG_DIR  = 2'd1;
  localparam logic [1:0] REG_OWN  = 2'd2;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_PORT,
    RD_PINS,
    RD_CFG_WIDTH,
    RD_CFG_COUNT
  } rdSrc_e;

  typedef struct packed {
    logic       wrStb;
    logic [1:0] port;
    logic [1:0] regIdx;
    rdSrc_e     rdSrc;
  } ctrlStb_t;
endpackage

// File: rtl/gpb_ctrl.sv
module gpb_ctrl
  import gpb_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 7
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output logic              pready,
  output logic              pslverr,
  output ctrlStb_t          stb
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic [1:0]        unusedAddr;

  assign word       = paddr[ADDR_W-1:2];
  assign unusedAddr = paddr[1:0];
  assign pready     = 1'b1;
  assign pslverr    = 1'b0;

  always_comb begin
    stb.wrStb  = 1'b0;
    stb.port   = 2'd0;
    stb.regIdx = REG_DATA;
    stb.rdSrc  = RD_NONE;
    if (word < WORD_W'(12)) begin
      stb.port   = 2'(word / WORD_W'(3));
      stb.regIdx = 2'(word % WORD_W'(3));
      if (int'(stb.port) < NUM_PORTS) stb.rdSrc = RD_PORT;
    end else if (word >= WORD_W'(20) && word <= WORD_W'(23)) begin
      stb.port  = 2'(word - WORD_W'(20));
      stb.rdSrc = RD_PINS;
    end else if (word == WORD_W'(28)) begin
      stb.rdSrc = RD_CFG_WIDTH;
    end else if (word == WORD_W'(29)) begin
      stb.rdSrc = RD_CFG_COUNT;
    end
    stb.wrStb = psel && penable && pwrite && (stb.rdSrc == RD_PORT);
  end
endmodule

// File: rtl/gpb_datapath.sv
module gpb_datapath
  import gpb_pkg::*;
#(
  parameter int                 NUM_PORTS  = 4,
  parameter logic [PIN_W-1:0]   IMPL_MASK  = '1,
  parameter logic [19:0]        CFG_WIDTHS = '1
) (
  input  logic             pclk,
  input  logic             presetn,
  input  ctrlStb_t         stb,
  input  logic [31:0]      pwdata,
  output logic [31:0]      prdata,
  input  logic [PIN_W-1:0] pinIn,
  input  logic [PIN_W-1:0] hwIn,
  output logic [PIN_W-1:0] padOut,
  output logic [PIN_W-1:0] padOe
);
  logic [MAX_PORTS-1:0][SLOT_W-1:0] dataW;
  logic [MAX_PORTS-1:0][SLOT_W-1:0] dirW;
  logic [MAX_PORTS-1:0][SLOT_W-1:0] ownW;
  logic [MAX_PORTS-1:0][SLOT_W-1:0] pinsW;

  for (genvar p = 0; p < MAX_PORTS; p++) begin : gPort
    localparam logic [SLOT_W-1:0] MASK = IMPL_MASK[p*SLOT_W +: SLOT_W];
    if (p < NUM_PORTS) begin : gLive
      logic [SLOT_W-1:0] dataQ, dirQ, ownQ, syncAQ, syncBQ;
      logic hitPort;
      assign hitPort = stb.wrStb && (int'(stb.port) == p);

      always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
          dataQ <= '0;
          dirQ  <= '0;
          ownQ  <= '0;
        end else if (hitPort) begin
          case (stb.regIdx)
            REG_DATA: dataQ <= pwdata & MASK;
            REG_DIR:  dirQ  <= pwdata & MASK;
            REG_OWN:  ownQ  <= pwdata & MASK;
            default:  ;
          endcase
        end
      end

      always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
          syncAQ <= '0;
          syncBQ <= '0;
        end else begin
          syncAQ <= pinIn[p*SLOT_W +: SLOT_W] & MASK;
          syncBQ <= syncAQ;
        end
      end

      assign dataW[p] = dataQ;
      assign dirW[p]  = dirQ;
      assign ownW[p]  = ownQ;
      assign pinsW[p] = syncBQ;
      assign padOut[p*SLOT_W +: SLOT_W] =
        ((ownQ & hwIn[p*SLOT_W +: SLOT_W]) | (~ownQ & dataQ)) & MASK;
      assign padOe[p*SLOT_W +: SLOT_W] = dirQ;
    end else begin : gAbsent
      logic [SLOT_W-1:0] unusedPins;
      assign unusedPins = pinIn[p*SLOT_W +: SLOT_W] ^ hwIn[p*SLOT_W +: SLOT_W];
      assign dataW[p] = '0;
      assign dirW[p]  = '0;
      assign ownW[p]  = '0;
      assign pinsW[p] = '0;
      assign padOut[p*SLOT_W +: SLOT_W] = '0;
      assign padOe[p*SLOT_W +: SLOT_W]  = '0;
    end
  end

  always_comb begin
    prdata = '0;
    case (stb.rdSrc)
      RD_PORT: begin
        case (stb.regIdx)
          REG_DATA: prdata = dataW[stb.port];
          REG_DIR:  prdata = dirW[stb.port];
          REG_OWN:  prdata = ownW[stb.port];
          default:  prdata = '0;
        endcase
      end
      RD_PINS:      prdata = pinsW[stb.port];
      RD_CFG_WIDTH: prdata = {12'd0, CFG_WIDTHS};
      RD_CFG_COUNT: prdata = {28'd0, 2'(NUM_PORTS - 1), 2'b00};
      default:      prdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpb_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int A_WIDTH   = 32,
  parameter int B_WIDTH   = 32,
  parameter int C_WIDTH   = 32,
  parameter int D_WIDTH   = 32,
  parameter int ADDR_W    = 7
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [4*32-1:0]   pinIn,
  input  logic [4*32-1:0]   hwIn,
  output logic [4*32-1:0]   padOut,
  output logic [4*32-1:0]   padOe
);
  function automatic int widthOf(input int p);
    case (p)
      0:       return A_WIDTH;
      1:       return B_WIDTH;
      2:       return C_WIDTH;
      default: return D_WIDTH;
    endcase
  endfunction

  function automatic logic [PIN_W-1:0] buildMask();
    logic [PIN_W-1:0] m = '0;
    for (int p = 0; p < MAX_PORTS; p++)
      if (p < NUM_PORTS)
        m[p*SLOT_W +: SLOT_W] = 32'((64'd1 << widthOf(p)) - 64'd1);
    return m;
  endfunction

  function automatic logic [19:0] buildCfg();
    logic [19:0] c = '0;
    for (int p = 0; p < MAX_PORTS; p++)
      if (p < NUM_PORTS) c[p*5 +: 5] = 5'(widthOf(p) - 1);
    return c;
  endfunction

  localparam logic [PIN_W-1:0] IMPL_MASK  = buildMask();
  localparam logic [19:0]      CFG_WIDTHS = buildCfg();

  ctrlStb_t stb;

  gpb_ctrl #(
    .NUM_PORTS(NUM_PORTS),
    .ADDR_W   (ADDR_W)
  ) uCtrl (
    .psel   (psel),
    .penable(penable),
    .pwrite (pwrite),
    .paddr  (paddr),
    .pready (pready),
    .pslverr(pslverr),
    .stb    (stb)
  );

  gpb_datapath #(
    .NUM_PORTS (NUM_PORTS),
    .IMPL_MASK (IMPL_MASK),
    .CFG_WIDTHS(CFG_WIDTHS)
  ) uData (
    .pclk   (pclk),
    .presetn(presetn),
    .stb    (stb),
    .pwdata (pwdata),
    .prdata (prdata),
    .pinIn  (pinIn),
    .hwIn   (hwIn),
    .padOut (padOut),
    .padOe  (padOe)
  );
endmodule

// File: rtl/gpio_port_bank_chk.sv
module gpio_port_bank_chk #(
  parameter int NUM_PORTS = 4,
  parameter int A_WIDTH   = 32,
  parameter int ADDR_W    = 7
) (
  input logic              pclk,
  input logic              presetn,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic [31:0]       prdata,
  input logic              pready,
  input logic              pslverr,
  input logic [4*32-1:0]   pinIn,
  input logic [4*32-1:0]   padOut,
  input logic [4*32-1:0]   padOe
);
  localparam logic [31:0] MASK_A = 32'((64'd1 << A_WIDTH) - 64'd1);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic accWr, accRd;
  logic [1:0] sinceRst;

  assign word  = paddr[ADDR_W-1:2];
  assign accWr = psel && penable && pwrite;
  assign accRd = psel && penable && !pwrite;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) sinceRst <= '0;
    else if (sinceRst != 2'd2) sinceRst <= sinceRst + 2'd1;
  end

  p_reset_r1: assert property (@(posedge pclk)
    !presetn |=> (padOe == '0 && padOut == '0));

  p_resp_r8: assert property (@(posedge pclk) disable iff (!presetn)
    (pready && !pslverr));

  p_dirwrite_r3: assert property (@(posedge pclk) disable iff (!presetn)
    (accWr && word == WORD_W'(1)) |=> (padOe[31:0] == ($past(pwdata) & MASK_A)));

  p_datawrite_keeps_oe_r2: assert property (@(posedge pclk) disable iff (!presetn)
    (accWr && word == WORD_W'(0)) |=> $stable(padOe));

  p_count_r7: assert property (@(posedge pclk) disable iff (!presetn)
    (accRd && word == WORD_W'(29)) |-> (prdata == 32'((NUM_PORTS - 1) << 2)));

  p_unmapped_r9: assert property (@(posedge pclk) disable iff (!presetn)
    (accRd && ((word >= WORD_W'(12) && word <= WORD_W'(19)) ||
               (word >= WORD_W'(24) && word <= WORD_W'(27)) ||
               word >= WORD_W'(30))) |-> (prdata == 32'd0));

  p_pinsync_r5: assert property (@(posedge pclk) disable iff (!presetn)
    (sinceRst == 2'd2 && accRd && word == WORD_W'(20)) |->
      (prdata == ($past(pinIn[31:0], 2) & MASK_A)));
endmodule

bind gpio_port_bank gpio_port_bank_chk #(
  .NUM_PORTS(NUM_PORTS),
  .A_WIDTH  (A_WIDTH),
  .ADDR_W   (ADDR_W)
) uChk (.*);

// File: tb/tb_gpio_port_bank.sv
module tb_gpio_port_bank;
  localparam int NP = 3;
  localparam int W0 = 8, W1 = 5, W2 = 32, W3 = 4;

  logic pclk = 1'b0;
  logic presetn = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [6:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr;
  logic [127:0] pinIn = '0, hwIn = '0;
  logic [127:0] padOut, padOe;

  int nChecks = 0, nFail = 0;
  bit done = 0;
  logic [31:0] sh [4][3];

  always #10 pclk = ~pclk;

  gpio_port_bank #(
    .NUM_PORTS(NP), .A_WIDTH(W0), .B_WIDTH(W1), .C_WIDTH(W2), .D_WIDTH(W3), .ADDR_W(7)
  ) dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
    .pinIn(pinIn), .hwIn(hwIn), .padOut(padOut), .padOe(padOe)
  );

  function automatic logic [31:0] mk(input int p);
    int w;
    if (p >= NP) return 32'd0;
    w = (p == 0) ? W0 : (p == 1) ? W1 : (p == 2) ? W2 : W3;
    return 32'((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [31:0] cfgWidths();
    logic [31:0] c = '0;
    c[4:0]   = 5'(W0 - 1);
    c[9:5]   = 5'(W1 - 1);
    c[14:10] = 5'(W2 - 1);
    return c;
  endfunction

  function automatic logic [31:0] expRead(input int word);
    if (word < 12) return (word / 3 < NP) ? sh[word / 3][word % 3] : 32'd0;
    if (word >= 20 && word <= 23) return pinIn[(word - 20)*32 +: 32] & mk(word - 20);
    if (word == 28) return cfgWidths();
    if (word == 29) return 32'((NP - 1) << 2);
    return 32'd0;
  endfunction

  function automatic string reqOf(input int word);
    if (word < 12) return (word / 3 < NP) ? "R2/R10" : "R9";
    if (word >= 20 && word <= 23) return "R5/R9";
    if (word == 28) return "R6";
    if (word == 29) return "R7";
    return "R9";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic checkOuts(input string tag);
    for (int p = 0; p < 4; p++) begin
      logic [31:0] eo;
      eo = ((sh[p][2] & hwIn[p*32 +: 32]) | (~sh[p][2] & sh[p][0])) & mk(p);
      check({tag, " R4 padOut"}, padOut[p*32 +: 32], eo);
      check({tag, " R3 padOe"}, padOe[p*32 +: 32], sh[p][1]);
    end
  endtask

  task automatic apbWrite(input int addr, input logic [31:0] d);
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = 1; paddr = 7'(addr); pwdata = d;
    @(negedge pclk);
    penable = 1; #1;
    check("R8 pready", {31'd0, pready}, 32'd1);
    check("R8 pslverr", {31'd0, pslverr}, 32'd0);
    @(negedge pclk);
    psel = 0; penable = 0; pwrite = 0;
    if (addr / 4 < 12 && (addr / 4) / 3 < NP)
      sh[(addr / 4) / 3][(addr / 4) % 3] = d & mk((addr / 4) / 3);
    #1;
  endtask

  task automatic apbRead(input int addr, output logic [31:0] d);
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = 0; paddr = 7'(addr);
    @(negedge pclk);
    penable = 1; #1;
    d = prdata;
    check("R8 pready", {31'd0, pready}, 32'd1);
    @(negedge pclk);
    psel = 0; penable = 0;
  endtask

  task automatic sweep(input logic [31:0] seed);
    logic [31:0] rd;
    for (int w = 0; w < 32; w++) begin
      apbWrite(w * 4, seed ^ (32'(w) * 32'h0103_0507));
      checkOuts("sweep");
    end
    for (int w = 0; w < 32; w++) begin
      apbRead(w * 4, rd);
      check(reqOf(w), rd, expRead(w));
    end
  endtask

  initial begin
    logic [31:0] rd;
    for (int p = 0; p < 4; p++) for (int r = 0; r < 3; r++) sh[p][r] = '0;
    repeat (3) @(negedge pclk);
    #1;
    checkOuts("R1 reset");
    presetn = 1;
    for (int w = 0; w < 12; w++) begin
      apbRead(w * 4, rd);
      check("R1 reset regs", rd, 32'd0);
    end
    apbRead(32'h70, rd); check("R6 width cfg", rd, 32'h0000_7C87);
    apbRead(32'h74, rd); check("R7 port count", rd, 32'h0000_0008);

    pinIn = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    hwIn  = 128'hF0F0_0F0F_AAAA_5555_3333_CCCC_9696_6969;
    sweep(32'hFFFF_FFFF);
    sweep(32'h5A5A_3C3C);
    sweep(32'h0000_0000);

    // R4: ownership mux with hardware sources changing
    apbWrite(32'h00, 32'h0000_00F0);
    apbWrite(32'h08, 32'h0000_00CC);
    apbWrite(32'h14, 32'h0000_0015);
    apbWrite(32'h20, 32'hFFFF_0000);
    apbWrite(32'h18, 32'h1234_5678);
    for (int k = 0; k < 4; k++) begin
      @(negedge pclk);
      hwIn = {4{32'hA5A5_A5A5 ^ (32'(k) * 32'h1111_1111)}};
      #1;
      checkOuts("R4 hwmux");
    end

    // R5: synchronizer latency on port A and C
    apbWrite(32'h00, 32'h0); apbWrite(32'h08, 32'h0);
    @(negedge pclk);
    pinIn[31:0] = 32'h0000_0011;
    psel = 1; penable = 0; pwrite = 0; paddr = 7'h50;
    @(negedge pclk); penable = 1; #1;
    check("R5 old level one edge later", prdata, 32'h0000_0010);
    @(negedge pclk); psel = 0; penable = 0;
    @(negedge pclk);
    pinIn[95:64] = 32'hDEAD_BEEF;
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = 0; paddr = 7'h58;
    @(negedge pclk); penable = 1; #1;
    check("R5 new level two edges later", prdata, 32'hDEAD_BEEF);
    @(negedge pclk); psel = 0; penable = 0;
    apbRead(32'h5C, rd); check("R5/R9 absent port pins", rd, 32'd0);

    // R11: setup phase alone writes nothing
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = 1; paddr = 7'h04; pwdata = 32'hFF;
    @(negedge pclk);
    psel = 0; pwrite = 0;
    #1;
    check("R11 padOe after setup-only", padOe[31:0], sh[0][1]);
    apbRead(32'h04, rd); check("R11 dir after setup-only", rd, sh[0][1]);

    // R10: upper bits of narrow port B
    apbWrite(32'h10, 32'hFFFF_FFFF);
    check("R10 padOe port B", padOe[63:32], 32'h0000_001F);
    apbRead(32'h10, rd); check("R10 dir port B", rd, 32'h0000_001F);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge pclk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule